// File: doc/BRIEF.md
# Receive Descriptor Ring Writeback Engine

This block sits between a receive byte stream and system memory. Bytes arrive one per beat, with a flag for the final byte of a frame and a flag reporting a line error. The whole frame is gathered in a local buffer first. Only then does the engine look at the next descriptor in a circular chain. Each descriptor is four 32-bit words: status, control/size, buffer address and next pointer. If hardware owns that descriptor, the engine copies the frame into the descriptor's buffer. It then writes a status word that hands the descriptor back to software, and it follows the next pointer.

Software controls the engine with an enable bit, a ring base address and two forwarding bits. One forwarding bit keeps short frames, the other keeps frames with errors. When a frame has no hardware-owned descriptor to go into, it is thrown away and an overflow counter is incremented. Memory is reached through a simple word port. Read data comes back one cycle after the request.

Top module: `rx_ring_writeback`

## Requirements
- R1: After reset, rx_ready is 1, mem_req is 0 and ovf_count is 0.
- R2: Once the final byte of a frame is accepted, the engine reads four consecutive words from the current descriptor pointer: byte offsets 0 (status), 4 (control/size), 8 (buffer address) and 12 (next pointer). It makes these reads before any write.
- R3: If bit 31 of the fetched status word is 0, the frame is discarded and nothing is written. ovf_count increases by exactly one and the pointer stays where it is.
- R4: Frame data is written only after the whole frame has been received. No memory access takes place while a byte is being accepted. Frame byte i lands in the word at buffer address + 4*(i/4), in bits 8*(i%4)+7 down to 8*(i%4). Unused bytes of the last word are zero.
- R5: After the data, one write goes to the descriptor's status address. In that word, bit 31 is 0 and bits 29:16 hold the received frame length in bytes (14 bits).
- R6: A frame shorter than 64 bytes is a runt. A runt sets status bits 1 and 30. With cfg_fwd_runt at 0, a runt is dropped with no writes and the pointer and ovf_count stay unchanged. A frame of exactly 64 bytes is not a runt.
- R7: A frame whose final beat has rx_err high sets status bits 3 and 30. With cfg_fwd_err at 0 it is dropped with no writes.
- R8: A frame longer than bits 13:0 of the control/size word, or longer than the local buffer, is flagged too long. It sets status bits 7 and 30 and is handled as an errored frame under R7. When it is kept, only min(length, size) bytes are written.
- R9: After a status writeback, the descriptor pointer takes the fetched next-pointer word. This lets the chain wrap around to its first descriptor.
- R10: While cfg_en is 0, incoming bytes are accepted and dropped with no memory access, and the descriptor pointer reloads from cfg_ring_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Engine enable |
| cfg_fwd_runt | input | 1 | Keep frames shorter than 64 bytes |
| cfg_fwd_err | input | 1 | Keep errored or too-long frames |
| cfg_ring_base | input | ADDR_W | Address of the first descriptor |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 1 | Frame error, sampled on every accepted beat |
| rx_ready | output | 1 | Engine accepts a byte this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| ovf_count | output | OVF_W | Frames lost because no descriptor was owned |

## Verification
The hardest case to reach from the ports is the engine arriving back at a descriptor that software has not yet returned. This needs a ring that has wrapped fully, so that the pointer lands on a slot the engine itself just closed. The bench drives frames through every slot of a three-entry chain, including a forwarded runt. The next frame then finds the first slot still owned by software, which forces the overflow path. Slots are re-armed only between frames. The bench also changes one slot's size word to force the truncating too-long case, and toggles the enable to show the pointer reloading from the base rather than continuing from where it stopped.

// File: rtl/rxwb_pkg.sv
// Shared definitions for the receive ring writeback engine.
// Holds the control state encoding and the status word bit positions
// that software decodes.
package rxwb_pkg;

    typedef enum logic [2:0] {
        ST_RECV,
        ST_FETCH,
        ST_DECIDE,
        ST_WRDATA,
        ST_WRSTAT
    } rxwb_state_e;

    localparam int BIT_OWN    = 31;
    localparam int BIT_ANYERR = 30;
    localparam int BIT_LONG   = 7;
    localparam int BIT_LINE   = 3;
    localparam int BIT_RUNT   = 1;
    localparam int LEN_LSB    = 16;

endpackage

// File: rtl/rxwb_frame_store.sv
// Frame collection buffer.
// Packs incoming bytes little-endian into 32-bit words and counts the
// frame length, saturating at the field width. It also remembers whether
// any beat carried an error. Bytes beyond the capacity are counted but
// not stored.
// Assumes FIFO_WORDS is a power of two. clear has priority over push.
module rxwb_frame_store #(
    parameter int FIFO_WORDS = 512,
    parameter int LEN_W      = 14,
    localparam int IDX_W     = $clog2(FIFO_WORDS),
    localparam int CAP       = FIFO_WORDS * 4,
    localparam int CNT_W     = $clog2(CAP) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [7:0]       byte_in,
    input  logic             err_in,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_word,
    output logic [LEN_W-1:0] frame_len,
    output logic             err_seen,
    output logic [CNT_W-1:0] stored
);

    logic [31:0]      words_q [FIFO_WORDS];
    logic [31:0]      acc_q;
    logic [31:0]      acc_next;
    logic [CNT_W-1:0] fill_q;
    logic [LEN_W-1:0] len_q;
    logic             err_q;
    logic             room;
    logic [1:0]       lane;

    assign lane     = fill_q[1:0];
    assign room     = fill_q < CNT_W'(CAP);
    assign acc_next = acc_q | ({24'd0, byte_in} << {lane, 3'b000});

    // Store the partially built word on every accepted byte.
    always_ff @(posedge clk) begin
        if (push && room && !clear)
            words_q[fill_q[IDX_W+1:2]] <= acc_next;
    end

    // Track byte count, length, error and word accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fill_q <= '0;
            len_q  <= '0;
            err_q  <= 1'b0;
            acc_q  <= '0;
        end else if (push) begin
            if (len_q != {LEN_W{1'b1}})
                len_q <= len_q + 1'b1;
            err_q <= err_q | err_in;
            if (room) begin
                fill_q <= fill_q + 1'b1;
                acc_q  <= (lane == 2'd3) ? 32'd0 : acc_next;
            end
        end
    end

    assign rd_word   = words_q[rd_idx];
    assign frame_len = len_q;
    assign err_seen  = err_q;
    assign stored    = fill_q;

    p_fill_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(CAP));

endmodule

// File: rtl/rxwb_judge.sv
// Frame classification and status word assembly.
// Purely combinational. From the collected length, the error flag and the
// descriptor's size field it decides runt, too-long and drop. It also
// builds the status word and the number of data words to write.
module rxwb_judge
    import rxwb_pkg::*;
#(
    parameter int LEN_W    = 14,
    parameter int CNT_W    = 12,
    parameter int CAP      = 2048,
    parameter int RUNT_MIN = 64,
    parameter int NW_W     = 11
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic             err_seen,
    input  logic [CNT_W-1:0] stored,
    input  logic [LEN_W-1:0] size_field,
    input  logic             fwd_runt,
    input  logic             fwd_err,
    output logic [31:0]      status,
    output logic             drop,
    output logic [NW_W-1:0]  nwords
);

    logic             runt;
    logic             too_long;
    logic [CNT_W-1:0] nbytes;

    // Classify the frame and choose the stored byte count.
    always_comb begin
        runt     = 32'(frame_len) < RUNT_MIN;
        too_long = (frame_len > size_field) || (32'(frame_len) > CAP);
        if (32'(size_field) < 32'(stored))
            nbytes = CNT_W'(size_field);
        else
            nbytes = stored;
        nwords = NW_W'((32'(nbytes) + 32'd3) >> 2);
        drop   = (runt && !fwd_runt) || ((err_seen || too_long) && !fwd_err);
    end

    // Assemble the writeback status word with ownership returned.
    always_comb begin
        status                         = '0;
        status[LEN_LSB +: LEN_W]       = frame_len;
        status[BIT_RUNT]               = runt;
        status[BIT_LINE]               = err_seen;
        status[BIT_LONG]               = too_long;
        status[BIT_ANYERR]             = runt || err_seen || too_long;
        status[BIT_OWN]                = 1'b0;
    end

endmodule

// File: rtl/rx_ring_writeback.sv
// Receive descriptor ring writeback engine (top).
// Collects a frame, fetches the current four-word descriptor, then either
// discards the frame (no ownership, or a drop rule) or writes the data and
// a status word, and follows the next pointer.
// Assumes the memory returns read data one cycle after a read request and
// accepts a request every cycle.
module rx_ring_writeback
    import rxwb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int FIFO_WORDS = 512,
    parameter int LEN_W      = 14,
    parameter int RUNT_MIN   = 64,
    parameter int OVF_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_fwd_runt,
    input  logic              cfg_fwd_err,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_err,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic [OVF_W-1:0]  ovf_count
);

    localparam int IDX_W = $clog2(FIFO_WORDS);
    localparam int CAP   = FIFO_WORDS * 4;
    localparam int CNT_W = $clog2(CAP) + 1;
    localparam int NW_W  = IDX_W + 2;

    rxwb_state_e       state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [2:0]        fidx_q;
    logic [NW_W-1:0]   widx_q;
    logic [OVF_W-1:0]  ovf_q;
    logic              d_own;
    logic [LEN_W-1:0]  d_size;
    logic [ADDR_W-1:0] d_buf;
    logic [ADDR_W-1:0] d_next;

    logic              push;
    logic              clear;
    logic [31:0]       fifo_word;
    logic [LEN_W-1:0]  frame_len;
    logic              err_seen;
    logic [CNT_W-1:0]  stored;
    logic [31:0]       status;
    logic              drop;
    logic [NW_W-1:0]   nwords;

    assign rx_ready = (state_q == ST_RECV);
    assign push     = rx_valid && rx_ready && cfg_en;
    assign clear    = (state_q == ST_RECV && !cfg_en)
                   || (state_q == ST_DECIDE && (!d_own || drop))
                   || (state_q == ST_WRSTAT);

    rxwb_frame_store #(
        .FIFO_WORDS (FIFO_WORDS),
        .LEN_W      (LEN_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (push),
        .byte_in   (rx_data),
        .err_in    (rx_err),
        .rd_idx    (widx_q[IDX_W-1:0]),
        .rd_word   (fifo_word),
        .frame_len (frame_len),
        .err_seen  (err_seen),
        .stored    (stored)
    );

    rxwb_judge #(
        .LEN_W    (LEN_W),
        .CNT_W    (CNT_W),
        .CAP      (CAP),
        .RUNT_MIN (RUNT_MIN),
        .NW_W     (NW_W)
    ) i_judge (
        .frame_len  (frame_len),
        .err_seen   (err_seen),
        .stored     (stored),
        .size_field (d_size),
        .fwd_runt   (cfg_fwd_runt),
        .fwd_err    (cfg_fwd_err),
        .status     (status),
        .drop       (drop),
        .nwords     (nwords)
    );

    // Sequence frame collection, descriptor fetch, decision and writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RECV;
            ptr_q   <= '0;
            fidx_q  <= '0;
            widx_q  <= '0;
            ovf_q   <= '0;
            d_own   <= 1'b0;
            d_size  <= '0;
            d_buf   <= '0;
            d_next  <= '0;
        end else begin
            case (state_q)
                ST_RECV: begin
                    if (!cfg_en) begin
                        ptr_q <= cfg_ring_base;
                    end else if (push && rx_last) begin
                        state_q <= ST_FETCH;
                        fidx_q  <= '0;
                    end
                end
                ST_FETCH: begin
                    fidx_q <= fidx_q + 1'b1;
                    case (fidx_q)
                        3'd1:    d_own  <= mem_rdata[BIT_OWN];
                        3'd2:    d_size <= mem_rdata[LEN_W-1:0];
                        3'd3:    d_buf  <= mem_rdata;
                        3'd4:    d_next <= mem_rdata;
                        default: ;
                    endcase
                    if (fidx_q == 3'd4)
                        state_q <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (!d_own) begin
                        ovf_q   <= ovf_q + 1'b1;
                        state_q <= ST_RECV;
                    end else if (drop) begin
                        state_q <= ST_RECV;
                    end else if (nwords == '0) begin
                        state_q <= ST_WRSTAT;
                    end else begin
                        widx_q  <= '0;
                        state_q <= ST_WRDATA;
                    end
                end
                ST_WRDATA: begin
                    widx_q <= widx_q + 1'b1;
                    if (widx_q == nwords - 1'b1)
                        state_q <= ST_WRSTAT;
                end
                ST_WRSTAT: begin
                    ptr_q   <= d_next;
                    state_q <= ST_RECV;
                end
                default: state_q <= ST_RECV;
            endcase
        end
    end

    // Drive the memory port from the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req  = (fidx_q < 3'd4);
                mem_addr = ptr_q + ADDR_W'({fidx_q, 2'b00});
            end
            ST_WRDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = d_buf + ADDR_W'({widx_q, 2'b00});
                mem_wdata = fifo_word;
            end
            ST_WRSTAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr_q;
                mem_wdata = status;
            end
            default: ;
        endcase
    end

    assign ovf_count = ovf_q;

    p_quiet_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |-> !mem_req);

    p_own_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRSTAT) |-> (mem_we && !mem_wdata[BIT_OWN]));

    p_ovf_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q != $past(ovf_q)) |-> (ovf_q == $past(ovf_q) + 1'b1));

    p_ptr_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |->
            ($past(state_q) == ST_WRSTAT || ($past(state_q) == ST_RECV && !$past(cfg_en))));

endmodule

// File: tb/test_rx_ring_writeback.sv
`timescale 1ns/1ps
module test_rx_ring_writeback;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_fwd_runt = 1'b0;
    logic        cfg_fwd_err = 1'b0;
    logic [31:0] cfg_ring_base = 32'h100;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic        rx_last = 1'b0;
    logic        rx_err = 1'b0;
    logic        rx_ready;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic [15:0] ovf_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } txn_t;
    txn_t  exp_q[$];
    string tag_q[$];

    logic [31:0] mem [0:4095];

    always #4 clk = ~clk;

    rx_ring_writeback i_rx_ring_writeback (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_fwd_runt(cfg_fwd_runt),
        .cfg_fwd_err(cfg_fwd_err), .cfg_ring_base(cfg_ring_base),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ovf_count(ovf_count)
    );

    // Memory model: one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[13:2]];
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compare every memory access with the queue head.
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected access", mem_addr, 32'hFFFFFFFF);
            end else begin
                txn_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(mem_we == e.we && mem_addr == e.addr, {t, " access addr"}, mem_addr, e.addr);
                if (e.we) check(mem_wdata == e.data, {t, " write data"}, mem_wdata, e.data);
            end
        end
    end

    task automatic push_exp(input logic we, input logic [31:0] a, input logic [31:0] d, input string t);
        exp_q.push_back('{we: we, addr: a, data: d});
        tag_q.push_back(t);
    endtask

    task automatic exp_fetch(input logic [31:0] p);
        for (int k = 0; k < 4; k++) push_exp(1'b0, p + 32'(4 * k), 32'd0, "R2 fetch");
    endtask

    task automatic exp_data(input logic [31:0] b, input int nbytes, input int seed);
        for (int w = 0; w < (nbytes + 3) / 4; w++) begin
            logic [31:0] v;
            v = 32'd0;
            for (int k = 0; k < 4; k++)
                if (w * 4 + k < nbytes) v[8*k +: 8] = 8'(seed + w * 4 + k);
            push_exp(1'b1, b + 32'(4 * w), v, "R4 data");
        end
    endtask

    function automatic logic [31:0] stat(input int len, input bit runt, input bit lerr, input bit lng);
        logic [31:0] s;
        s = 32'd0;
        s[29:16] = 14'(len);
        s[1] = runt;
        s[3] = lerr;
        s[7] = lng;
        s[30] = runt | lerr | lng;
        return s;
    endfunction

    task automatic send(input int n, input int seed, input bit err);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed + i);
            rx_last  = (i == n - 1);
            rx_err   = err && (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        rx_err   = 1'b0;
        while (!rx_ready) @(negedge clk);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R4 all expected accesses seen", 32'(exp_q.size()), 32'd0);
    endtask

    task automatic arm(input logic [31:0] p, input logic [31:0] size, input logic [31:0] b, input logic [31:0] nx);
        mem[p[13:2]]     <= 32'h8000_0000;
        mem[p[13:2] + 1] <= size;
        mem[p[13:2] + 2] <= b;
        mem[p[13:2] + 3] <= nx;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] <= 32'd0;
        arm(32'h100, 32'd2044, 32'h1000, 32'h110);
        arm(32'h110, 32'd2044, 32'h1800, 32'h120);
        arm(32'h120, 32'd2044, 32'h2000, 32'h100);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_ready == 1'b1, "R1 rx_ready", 32'(rx_ready), 32'd1);
        check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
        check(ovf_count == 16'd0, "R1 ovf_count", 32'(ovf_count), 32'd0);
        repeat (2) @(negedge clk);
        cfg_en = 1'b1;

        // R5: normal frame into descriptor 0
        exp_fetch(32'h100); exp_data(32'h1000, 70, 8'h10); push_exp(1'b1, 32'h100, stat(70, 0, 0, 0), "R5 status");
        send(70, 8'h10, 0);
        check(mem[32'h100 >> 2] == 32'h0046_0000, "R5 status in memory", mem[32'h100 >> 2], 32'h0046_0000);

        // R6 boundary: exactly 64 bytes is not a runt
        exp_fetch(32'h110); exp_data(32'h1800, 64, 8'h40); push_exp(1'b1, 32'h110, stat(64, 0, 0, 0), "R6 64-byte status");
        send(64, 8'h40, 0);

        // R6: runt dropped when not forwarded
        exp_fetch(32'h120);
        send(40, 8'h77, 0);
        check(mem[32'h120 >> 2] == 32'h8000_0000, "R6 runt left descriptor owned", mem[32'h120 >> 2], 32'h8000_0000);
        check(ovf_count == 16'd0, "R6 runt drop no overflow", 32'(ovf_count), 32'd0);

        // R6: runt forwarded, same descriptor
        cfg_fwd_runt = 1'b1;
        exp_fetch(32'h120); exp_data(32'h2000, 40, 8'h80); push_exp(1'b1, 32'h120, stat(40, 1, 0, 0), "R6 runt status");
        send(40, 8'h80, 0);
        check(mem[32'h120 >> 2] == 32'h4028_0002, "R6 runt status value", mem[32'h120 >> 2], 32'h4028_0002);

        // R9 wrap to first descriptor, R3 not owned -> overflow
        exp_fetch(32'h100);
        send(70, 8'h99, 0);
        check(ovf_count == 16'd1, "R3 overflow count", 32'(ovf_count), 32'd1);
        check(mem[32'h100 >> 2] == 32'h0046_0000, "R3 status untouched", mem[32'h100 >> 2], 32'h0046_0000);
        check(mem[32'h1000 >> 2] == 32'h1312_1110, "R3 buffer untouched", mem[32'h1000 >> 2], 32'h1312_1110);

        // R7: errored frame dropped when not forwarded
        cfg_fwd_runt = 1'b0;
        @(negedge clk); mem[32'h100 >> 2] <= 32'h8000_0000; @(negedge clk);
        exp_fetch(32'h100);
        send(70, 8'h31, 1);
        check(mem[32'h100 >> 2] == 32'h8000_0000, "R7 errored frame dropped", mem[32'h100 >> 2], 32'h8000_0000);

        // R7: errored frame forwarded
        cfg_fwd_err = 1'b1;
        exp_fetch(32'h100); exp_data(32'h1000, 66, 8'hC0); push_exp(1'b1, 32'h100, stat(66, 0, 1, 0), "R7 error status");
        send(66, 8'hC0, 1);
        check(mem[32'h100 >> 2] == 32'h4042_0008, "R7 error status value", mem[32'h100 >> 2], 32'h4042_0008);

        // R8: frame longer than size field is truncated and flagged
        @(negedge clk);
        arm(32'h110, 32'd80, 32'h1800, 32'h120);
        mem[(32'h1800 >> 2) + 20] <= 32'hDEAD_BEEF;
        @(negedge clk);
        exp_fetch(32'h110); exp_data(32'h1800, 80, 8'h20); push_exp(1'b1, 32'h110, stat(100, 0, 0, 1), "R8 long status");
        send(100, 8'h20, 0);
        check(mem[32'h110 >> 2] == 32'h4064_0080, "R8 long status value", mem[32'h110 >> 2], 32'h4064_0080);
        check(mem[(32'h1800 >> 2) + 20] == 32'hDEAD_BEEF, "R8 truncated beyond size", mem[(32'h1800 >> 2) + 20], 32'hDEAD_BEEF);

        // R10: disabled engine swallows bytes and reloads pointer from base
        cfg_en = 1'b0;
        send(8, 8'h01, 0);
        check(ovf_count == 16'd1, "R10 disabled frame ignored", 32'(ovf_count), 32'd1);
        @(negedge clk);
        arm(32'h100, 32'd2044, 32'h1000, 32'h110);
        @(negedge clk);
        cfg_en = 1'b1;
        exp_fetch(32'h100); exp_data(32'h1000, 70, 8'h55); push_exp(1'b1, 32'h100, stat(70, 0, 0, 0), "R10 reload status");
        send(70, 8'h55, 0);
        check(ovf_count == 16'd1, "R10 pointer reloaded, no overflow", 32'(ovf_count), 32'd1);
        check(mem[32'h100 >> 2] == 32'h0046_0000, "R10 base descriptor written", mem[32'h100 >> 2], 32'h0046_0000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog covering R1 to R10 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule